// File: doc/BRIEF.md
# Daylight Saving Hour Adjuster

This block applies one-shot daylight-saving corrections to a running calendar hour. Software writes a control word with one of two command bits set. The forward command moves the hour one step ahead. The backward command moves the hour one step back. The block computes the corrected hour and raises a single-cycle update pulse, so the calendar can load that hour on the same clock. Minutes and seconds are not touched.

A forward step out of the last hour of the day wraps the hour to zero. On that step the block also raises a one-cycle day-carry pulse, so the date logic can advance. A backward step from hour zero is refused, so the block never needs to borrow from the day.

The same control word carries a keep flag. Software uses it to remember whether summer time is in effect. The flag is stored and read back, and it never alters the time. The two command bits are self-clearing and always read back as zero. Every write passes through a write-enable gate that models write protection. Commands are also refused while the calendar is in initialization mode.

Top module: `dst_hour_adjust`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `hour_out`, `hour_upd`, `day_carry` and `reg_rdata` are all 0.
- R2: An accepted write with bit 0 (forward) set and bit 1 clear, made outside initialization mode, makes `hour_out` equal `cur_hour`+1 after the next rising edge, with `hour_upd` high for that one cycle.
- R3: A forward command applied while `cur_hour` is 23 gives `hour_out` = 0 and `day_carry` high for one cycle. `day_carry` is never high except together with `hour_upd` and `hour_out` = 0.
- R4: An accepted write with bit 1 (backward) set and bit 0 clear, made outside initialization mode with `cur_hour` nonzero, makes `hour_out` equal `cur_hour`-1 after the next edge, with a one-cycle `hour_upd`.
- R5: A backward command made while `cur_hour` is 0 produces no `hour_upd`, and `hour_out` stays 0.
- R6: While `init_mode` is high, both command bits are ignored and no `hour_upd` occurs.
- R7: A write with bit 0 and bit 1 both set applies no adjustment.
- R8: A write with `reg_wr_en` low has no effect: no adjustment is made and the keep flag keeps its value.
- R9: Bit 2 (keep flag) of every accepted write is stored and shown on `reg_rdata[2]` from the next cycle on. This also holds in initialization mode, and the write alone causes no `hour_upd`.
- R10: `reg_rdata` bits 0 and 1, and every bit above bit 2, always read 0.
- R11: In any cycle without `hour_upd`, `hour_out` equals the `cur_hour` sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_mode | input | 1 | Calendar is in initialization mode; commands are refused |
| cur_hour | input | HR_W (5) | Current binary hour, 0 to HOURS-1 |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wr_en | input | 1 | Write permission (protection lifted when high) |
| reg_wdata | input | REG_W (8) | Control word: bit 0 forward, bit 1 backward, bit 2 keep flag |
| reg_rdata | output | REG_W (8) | Control-word readback: keep flag on bit 2, all other bits 0 |
| hour_out | output | HR_W (5) | Adjusted hour; otherwise follows `cur_hour` one cycle late |
| hour_upd | output | 1 | One-cycle pulse when an adjustment is applied |
| day_carry | output | 1 | One-cycle pulse when a forward step wraps past midnight |

## Verification
The bound checker checks on every cycle that an update pulse always follows a permitted write made outside initialization mode. It also checks that a conflicting write, a protected write or a backward write at hour zero never yields a pulse. Further cycle-by-cycle checks cover the day carry, which must appear only with a wrap to zero, the command bits, which must read as zero, and the unadjusted hour, which must follow the input hour one cycle late. Only the bench scenarios can show that the applied hour is the correct value at the boundaries (22, 23, 1 and 0). The bench scenarios also show the keep flag holding its value across protected writes and accepting new values in initialization mode.

// File: rtl/dst_pkg.sv
package dst_pkg;

  // Control-word field positions (software-visible layout)
  localparam int unsigned FWD_BIT  = 0;
  localparam int unsigned BACK_BIT = 1;
  localparam int unsigned KEEP_BIT = 2;
  localparam int unsigned CTL_USED = 3;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_FWD  = 2'd1,
    ADJ_BACK = 2'd2
  } adj_e;

  // Hour one step ahead, wrapping at the end of the day
  function automatic int unsigned hr_step_fwd(int unsigned h, int unsigned hours);
    if (h + 1 >= hours) return 0;
    return h + 1;
  endfunction

  // Hour one step back; hour zero is held (the caller refuses that case)
  function automatic int unsigned hr_step_back(int unsigned h);
    if (h == 0) return 0;
    return h - 1;
  endfunction

  // Does a forward step cross midnight?
  function automatic logic hr_wraps(int unsigned h, int unsigned hours);
    return (h + 1 >= hours);
  endfunction

endpackage

// File: rtl/dst_regif.sv
module dst_regif
  import dst_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             wr_ok,
  output logic             fwd_req,
  output logic             back_req,
  output logic [REG_W-1:0] reg_rdata
);

  logic keep_q;

  // Write protection gate
  assign wr_ok    = reg_wr & reg_wr_en;
  // Command bits are strobes only; they are never stored
  assign fwd_req  = wr_ok & reg_wdata[FWD_BIT];
  assign back_req = wr_ok & reg_wdata[BACK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= 1'b0;
    end else if (wr_ok) begin
      keep_q <= reg_wdata[KEEP_BIT];
    end
  end

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[KEEP_BIT] = keep_q;
  end

  generate
    if (REG_W > CTL_USED) begin : g_spare
      logic unused_spare_bits;
      assign unused_spare_bits = ^reg_wdata[REG_W-1:CTL_USED];
    end
  endgenerate

endmodule

// File: rtl/dst_cmd_arb.sv
module dst_cmd_arb
  import dst_pkg::*;
#(
  parameter int unsigned HR_W = 5
) (
  input  logic            fwd_req,
  input  logic            back_req,
  input  logic            init_mode,
  input  logic [HR_W-1:0] cur_hour,
  output adj_e            op,
  output logic            ev_conflict,
  output logic            ev_init_block,
  output logic            ev_zero_skip
);

  logic any_req;

  assign any_req       = fwd_req | back_req;
  assign ev_conflict   = fwd_req & back_req;
  assign ev_init_block = any_req & init_mode;
  assign ev_zero_skip  = back_req & ~fwd_req & ~init_mode & (cur_hour == '0);

  always_comb begin
    op = ADJ_NONE;
    if (!init_mode && !ev_conflict) begin
      if (fwd_req)                         op = ADJ_FWD;
      else if (back_req && !ev_zero_skip)  op = ADJ_BACK;
    end
  end

endmodule

// File: rtl/dst_hour_math.sv
module dst_hour_math
  import dst_pkg::*;
#(
  parameter int unsigned HR_W  = 5,
  parameter int unsigned HOURS = 24
) (
  input  logic [HR_W-1:0] cur_hour,
  input  adj_e            op,
  output logic [HR_W-1:0] nxt_hour,
  output logic            apply,
  output logic            wrap
);

  always_comb begin
    nxt_hour = cur_hour;
    apply    = 1'b0;
    wrap     = 1'b0;
    unique case (op)
      ADJ_FWD: begin
        nxt_hour = HR_W'(hr_step_fwd(32'(cur_hour), HOURS));
        wrap     = hr_wraps(32'(cur_hour), HOURS);
        apply    = 1'b1;
      end
      ADJ_BACK: begin
        nxt_hour = HR_W'(hr_step_back(32'(cur_hour)));
        apply    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dst_hour_adjust.sv
module dst_hour_adjust
  import dst_pkg::*;
#(
  parameter int unsigned HOURS = 24,
  parameter int unsigned REG_W = 8,
  localparam int unsigned HR_W = $clog2(HOURS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_mode,
  input  logic [HR_W-1:0]  cur_hour,
  input  logic             reg_wr,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [HR_W-1:0]  hour_out,
  output logic             hour_upd,
  output logic             day_carry
);

  // Internal events, named for the bound checker
  logic            wr_ok;
  logic            fwd_req;
  logic            back_req;
  adj_e            op;
  logic            ev_conflict;
  logic            ev_init_block;
  logic            ev_zero_skip;
  logic [HR_W-1:0] nxt_hour;
  logic            op_apply;
  logic            op_wrap;

  dst_regif #(.REG_W(REG_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .wr_ok     (wr_ok),
    .fwd_req   (fwd_req),
    .back_req  (back_req),
    .reg_rdata (reg_rdata)
  );

  dst_cmd_arb #(.HR_W(HR_W)) u_arb (
    .fwd_req       (fwd_req),
    .back_req      (back_req),
    .init_mode     (init_mode),
    .cur_hour      (cur_hour),
    .op            (op),
    .ev_conflict   (ev_conflict),
    .ev_init_block (ev_init_block),
    .ev_zero_skip  (ev_zero_skip)
  );

  dst_hour_math #(.HR_W(HR_W), .HOURS(HOURS)) u_math (
    .cur_hour (cur_hour),
    .op       (op),
    .nxt_hour (nxt_hour),
    .apply    (op_apply),
    .wrap     (op_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hour_out  <= '0;
      hour_upd  <= 1'b0;
      day_carry <= 1'b0;
    end else begin
      hour_out  <= op_apply ? nxt_hour : cur_hour;
      hour_upd  <= op_apply;
      day_carry <= op_apply & op_wrap;
    end
  end

endmodule

// File: rtl/dst_hour_adjust_chk.sv
module dst_hour_adjust_chk #(
  parameter int unsigned HR_W  = 5,
  parameter int unsigned REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_mode,
  input logic [HR_W-1:0]  cur_hour,
  input logic             reg_wr,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [HR_W-1:0]  hour_out,
  input logic             hour_upd,
  input logic             day_carry,
  input logic             ev_conflict,
  input logic             ev_init_block,
  input logic             ev_zero_skip
);

  // Set once a full non-reset cycle has passed, so $past never sees reset values
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && hour_upd) |-> $past(reg_wr && reg_wr_en && !init_mode)); // R2

  AST_CARRY_WITH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> (hour_upd && hour_out == '0)); // R3

  AST_ZERO_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ev_zero_skip)) |-> !hour_upd); // R5

  AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ev_init_block)) |-> !hour_upd); // R6

  AST_CONFLICT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(ev_conflict)) |-> !hour_upd); // R7

  AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(reg_wr_en)) |-> (!hour_upd && $stable(reg_rdata))); // R8

  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1:0] == 2'b00) && (reg_rdata >> 3 == '0)); // R10

  AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !hour_upd) |-> hour_out == $past(cur_hour)); // R11

  logic unused_chk;
  assign unused_chk = ^reg_wdata;

endmodule

bind dst_hour_adjust dst_hour_adjust_chk #(.HR_W(HR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/test_dst_hour_adjust.sv
module test_dst_hour_adjust;

  localparam int CLK_PERIOD = 10;
  localparam int HR_W  = 5;
  localparam int REG_W = 8;
  localparam int NV    = 16;

  typedef struct packed {
    logic [4:0] req;
    logic       init;
    logic       en;
    logic [2:0] d;      // {keep, backward, forward}
    logic [4:0] hr;
    logic [4:0] exp_hr;
    logic       exp_upd;
    logic       exp_cy;
    logic       exp_keep;
  } vec_t;

  // Each row: one write cycle, result checked one edge later
  localparam vec_t VECS [NV] = '{
    '{5'd2,  1'b0, 1'b1, 3'b001, 5'd5,  5'd6,  1'b1, 1'b0, 1'b0}, // R2
    '{5'd2,  1'b0, 1'b1, 3'b001, 5'd10, 5'd11, 1'b1, 1'b0, 1'b0}, // R2
    '{5'd3,  1'b0, 1'b1, 3'b001, 5'd23, 5'd0,  1'b1, 1'b1, 1'b0}, // R3 wrap
    '{5'd3,  1'b0, 1'b1, 3'b001, 5'd22, 5'd23, 1'b1, 1'b0, 1'b0}, // R3 no wrap
    '{5'd4,  1'b0, 1'b1, 3'b010, 5'd7,  5'd6,  1'b1, 1'b0, 1'b0}, // R4
    '{5'd4,  1'b0, 1'b1, 3'b010, 5'd1,  5'd0,  1'b1, 1'b0, 1'b0}, // R4
    '{5'd5,  1'b0, 1'b1, 3'b010, 5'd0,  5'd0,  1'b0, 1'b0, 1'b0}, // R5
    '{5'd6,  1'b1, 1'b1, 3'b001, 5'd15, 5'd15, 1'b0, 1'b0, 1'b0}, // R6
    '{5'd6,  1'b1, 1'b1, 3'b010, 5'd15, 5'd15, 1'b0, 1'b0, 1'b0}, // R6
    '{5'd7,  1'b0, 1'b1, 3'b011, 5'd9,  5'd9,  1'b0, 1'b0, 1'b0}, // R7
    '{5'd8,  1'b0, 1'b0, 3'b101, 5'd12, 5'd12, 1'b0, 1'b0, 1'b0}, // R8
    '{5'd9,  1'b0, 1'b1, 3'b100, 5'd12, 5'd12, 1'b0, 1'b0, 1'b1}, // R9
    '{5'd8,  1'b0, 1'b0, 3'b010, 5'd20, 5'd20, 1'b0, 1'b0, 1'b1}, // R8 keep held
    '{5'd9,  1'b1, 1'b1, 3'b000, 5'd3,  5'd3,  1'b0, 1'b0, 1'b0}, // R9 in init mode
    '{5'd2,  1'b0, 1'b1, 3'b101, 5'd18, 5'd19, 1'b1, 1'b0, 1'b1}, // R2 with keep
    '{5'd4,  1'b0, 1'b1, 3'b110, 5'd12, 5'd11, 1'b1, 1'b0, 1'b1}  // R4 with keep
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             init_mode;
  logic [HR_W-1:0]  cur_hour;
  logic             reg_wr;
  logic             reg_wr_en;
  logic [REG_W-1:0] reg_wdata;
  logic [REG_W-1:0] reg_rdata;
  logic [HR_W-1:0]  hour_out;
  logic             hour_upd;
  logic             day_carry;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dst_hour_adjust i_dst_hour_adjust (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_mode (init_mode),
    .cur_hour  (cur_hour),
    .reg_wr    (reg_wr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hour_out  (hour_out),
    .hour_upd  (hour_upd),
    .day_carry (day_carry)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, int hr, int upd, int cy, int keep);
    check({tag, " hour_out"},  int'(hour_out),  hr);
    check({tag, " hour_upd"},  int'(hour_upd),  upd);
    check({tag, " day_carry"}, int'(day_carry), cy);
    check({tag, " keep"},      int'(reg_rdata[2]), keep);
    check({tag, " R10 cmd/spare read"}, int'(reg_rdata & 8'hFB), 0);
  endtask

  initial begin
    rst_n = 1'b0; init_mode = 1'b0; cur_hour = 5'd8;
    reg_wr = 1'b0; reg_wr_en = 1'b1; reg_wdata = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    cur_hour = 5'd0;
    @(negedge clk);
    check_all("R1 first cycle", 0, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      init_mode = VECS[i].init;
      reg_wr_en = VECS[i].en;
      reg_wr    = 1'b1;
      reg_wdata = {5'b0, VECS[i].d};
      cur_hour  = VECS[i].hr;
      @(negedge clk);
      check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                VECS[i].exp_hr, VECS[i].exp_upd, VECS[i].exp_cy, VECS[i].exp_keep);
    end

    // R11: idle cycles follow the input hour, one cycle late
    reg_wr = 1'b0; init_mode = 1'b0; reg_wr_en = 1'b1; cur_hour = 5'd14;
    @(negedge clk);
    check_all("R11 idle", 14, 0, 0, 1);

    // R3: wrap pulse lasts a single cycle
    reg_wr = 1'b1; reg_wdata = 8'h01; cur_hour = 5'd23;
    @(negedge clk);
    check_all("R3 wrap pulse", 0, 1, 1, 0);
    reg_wr = 1'b0; cur_hour = 5'd0;
    @(negedge clk);
    check_all("R3 pulse ends", 0, 0, 0, 0);

    // R2: an update pulse lasts a single cycle
    reg_wr = 1'b1; reg_wdata = 8'h05; cur_hour = 5'd2;
    @(negedge clk);
    check_all("R2 pulse", 3, 1, 0, 1);
    reg_wr = 1'b0; cur_hour = 5'd3;
    @(negedge clk);
    check_all("R2 pulse ends", 3, 0, 0, 1);

    // R1: reset in mid-run clears the keep flag and the outputs
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule